// File: doc/BRIEF.md
# Interface-Control Register with Fault Indicator

This block holds one 8-bit PHY control register behind a simple register-access port. The register sits at three consecutive addresses. A write to the first address loads the whole value. A write to the second address sets the bits that are 1 in the data. A write to the third address clears the bits that are 1 in the data. A read at any of the three addresses returns the current value. A read at any other address returns 0.

The register fields drive the following controls:
- three alternative-interface mode enables: car-kit, 3-pin full/low-speed serial and 6-pin full/low-speed serial;
- an active-low clock-suspend control;
- an interface-protection disable.

The mode enables are mutually exclusive. If more than one mode bit is set, the block raises a conflict flag and leaves every mode output inactive.

The block also forms the external-fault indication. It can invert a FAULT input. It can then qualify the result with a VBUS-valid comparator input. The resulting bit feeds the VBUS-state field of a receive-command byte built elsewhere.

The access port has no handshake. A write strobe is accepted on every rising edge where it is high, so the port never applies back-pressure. Reads are combinational from the address, so the data is valid in the same cycle as the address.

Top module: `ulpi_ifc_ctrl`

## Requirements
- R1: After reset every register bit is 0. The readback is 0x00, all mode outputs are 0, the protection disable is 0 and the conflict flag is 0.
- R2: A write strobe at address 0x07 loads the write data on the next rising edge. Bit 4 is reserved: it always reads 0, even when written with 1.
- R3: A write strobe at address 0x08 ORs the write data into the register. Bit 4 stays 0.
- R4: A write strobe at address 0x09 clears each register bit whose data bit is 1. All other bits are left unchanged.
- R5: Reads at 0x07, 0x08 and 0x09 all return the register value. Reads at any other address return 0x00. Writes to any other address leave the register unchanged.
- R6: The fields have these positions: bit 7 = protection disable (prot_dis), bit 6 = indicator pass-through, bit 5 = indicator invert, bit 3 = clock-on during suspend (active-low suspend), bit 2 = car-kit mode, bit 1 = 3-pin serial mode, bit 0 = 6-pin serial mode. When exactly one mode bit is set, the matching mode output is 1.
- R7: When two or more of bits 2..0 are 1, mode_conflict is 1 and carkit_en, serial3_en and serial6_en are all 0.
- R8: The complement signal equals fault_in XOR bit 5.
- R9: When bit 6 is 0, vbus_ind = complement AND vbus_valid. When bit 6 is 1, vbus_ind = complement.
- R10: clk_powered = suspend_n AND (bit 3 when an effective serial mode is active, otherwise 1). An effective serial mode is serial3_en or serial6_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 8 | Combinational read data |
| fault_in | input | 1 | External fault input |
| vbus_valid | input | 1 | VBUS-valid comparator input |
| suspend_n | input | 1 | Active-low suspend input |
| prot_dis | output | 1 | Interface-protection disable |
| carkit_en | output | 1 | Car-kit mode enable |
| serial3_en | output | 1 | 3-pin serial mode enable |
| serial6_en | output | 1 | 6-pin serial mode enable |
| mode_conflict | output | 1 | More than one mode bit is set |
| clk_powered | output | 1 | Clock-on control |
| vbus_ind | output | 1 | VBUS-state indication bit |

## Verification
The register is driven through chained load, set and clear writes whose expected values differ bit by bit. This shows whether an alias replaces the value, merges into it or masks it, and whether the reserved bit ever sticks. Reads and writes at the addresses just outside the window separate the three aliases from a decode that is too wide.

The indicator path is tried with all combinations of fault and VBUS-valid under each invert and pass-through setting. This shows whether the inversion and the qualification are each applied, and in the right order.

The clock control is tried with a single serial mode, a conflicting pair, a mode-free setting, and the suspend input low. This shows that bit 3 is used only when a valid serial mode is active.

// File: rtl/ifc_ctrl_pkg.sv
package ifc_ctrl_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int BASE_ADDR  = 7;

  // field positions
  localparam int B_PROT_DIS = 7;
  localparam int B_PASS     = 6;
  localparam int B_INVERT   = 5;
  localparam int B_RSVD     = 4;
  localparam int B_CLK_ON   = 3;
  localparam int MODE_LSB   = 0;
  localparam int MODE_N     = 3;

  // mode index within the mode field
  localparam int M_SER6     = 0;
  localparam int M_SER3     = 1;
  localparam int M_CARKIT   = 2;

  localparam logic [DATA_W-1:0] RSVD_MASK = ~(DATA_W'(1) << B_RSVD);

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/ifc_ctrl_regfile.sv
module ifc_ctrl_regfile
  import ifc_ctrl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BASE = BASE_ADDR,
  parameter logic [DW-1:0] KEEP_MASK = RSVD_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] value,
  output logic          rd_hit
);
  localparam logic [AW-1:0] A_LOAD = AW'(BASE);
  localparam logic [AW-1:0] A_SET  = AW'(BASE + 1);
  localparam logic [AW-1:0] A_CLR  = AW'(BASE + 2);

  wr_op_e        op;
  logic [DW-1:0] nxt;
  logic [DW-1:0] q;

  always_comb begin
    unique case (addr)
      A_LOAD:  op = OP_LOAD;
      A_SET:   op = OP_SET;
      A_CLR:   op = OP_CLR;
      default: op = OP_NONE;
    endcase
  end

  assign rd_hit = (op != OP_NONE);

  always_comb begin
    nxt = q;
    if (we) begin
      case (op)
        OP_LOAD: nxt = wdata;
        OP_SET:  nxt = q | wdata;
        OP_CLR:  nxt = q & ~wdata;
        default: nxt = q;
      endcase
    end
    nxt = nxt & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign value = q;
endmodule

// File: rtl/ifc_mode_decode.sv
module ifc_mode_decode #(
  parameter int N = 3
) (
  input  logic [N-1:0] mode_bits,
  output logic [N-1:0] mode_en,
  output logic         conflict
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(mode_bits[i]);
  end

  assign conflict = (cnt > CW'(1));

  for (genvar g = 0; g < N; g++) begin : g_en
    assign mode_en[g] = mode_bits[g] & ~conflict;
  end
endmodule

// File: rtl/ifc_fault_ind.sv
module ifc_fault_ind (
  input  logic fault_in,
  input  logic vbus_valid,
  input  logic invert,
  input  logic pass_thru,
  output logic ind
);
  logic compl_sig;
  assign compl_sig = fault_in ^ invert;
  assign ind = pass_thru ? compl_sig : (compl_sig & vbus_valid);
endmodule

// File: rtl/ifc_clk_ctl.sv
module ifc_clk_ctl (
  input  logic suspend_n,
  input  logic serial_on,
  input  logic clk_on_bit,
  output logic clk_powered
);
  assign clk_powered = suspend_n & (serial_on ? clk_on_bit : 1'b1);
endmodule

// File: rtl/ulpi_ifc_ctrl.sv
module ulpi_ifc_ctrl
  import ifc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fault_in,
  input  logic              vbus_valid,
  input  logic              suspend_n,
  output logic              prot_dis,
  output logic              carkit_en,
  output logic              serial3_en,
  output logic              serial6_en,
  output logic              mode_conflict,
  output logic              clk_powered,
  output logic              vbus_ind
);
  logic [DATA_W-1:0] ctrl_q;
  logic              rd_hit;
  logic [MODE_N-1:0] mode_en;

  ifc_ctrl_regfile #(
    .AW(ADDR_W), .DW(DATA_W), .BASE(BASE_ADDR), .KEEP_MASK(RSVD_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .value(ctrl_q), .rd_hit(rd_hit)
  );

  assign reg_rdata = rd_hit ? ctrl_q : '0;

  ifc_mode_decode #(.N(MODE_N)) u_modes (
    .mode_bits(ctrl_q[MODE_LSB +: MODE_N]),
    .mode_en(mode_en),
    .conflict(mode_conflict)
  );

  assign carkit_en  = mode_en[M_CARKIT];
  assign serial3_en = mode_en[M_SER3];
  assign serial6_en = mode_en[M_SER6];
  assign prot_dis   = ctrl_q[B_PROT_DIS];

  ifc_fault_ind u_ind (
    .fault_in(fault_in), .vbus_valid(vbus_valid),
    .invert(ctrl_q[B_INVERT]), .pass_thru(ctrl_q[B_PASS]),
    .ind(vbus_ind)
  );

  ifc_clk_ctl u_clk (
    .suspend_n(suspend_n),
    .serial_on(mode_en[M_SER3] | mode_en[M_SER6]),
    .clk_on_bit(ctrl_q[B_CLK_ON]),
    .clk_powered(clk_powered)
  );
endmodule

// File: rtl/ulpi_ifc_ctrl_chk.sv
module ulpi_ifc_ctrl_chk
  import ifc_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              vbus_valid,
  input logic              suspend_n,
  input logic              carkit_en,
  input logic              serial3_en,
  input logic              serial6_en,
  input logic              clk_powered,
  input logic              vbus_ind
);
  localparam logic [ADDR_W-1:0] A0 = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(BASE_ADDR + 2);

  logic out_of_win;
  assign out_of_win = (reg_addr != A0) && (reg_addr != A1) && (reg_addr != A2);

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[B_RSVD]); // R2
  AST_LOAD_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A0 |=> ctrl_q == ($past(reg_wdata) & RSVD_MASK)); // R2
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A1 |=> ctrl_q == (($past(ctrl_q) | $past(reg_wdata)) & RSVD_MASK)); // R3
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A2 |=> ctrl_q == ($past(ctrl_q) & ~$past(reg_wdata))); // R4
  AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && out_of_win |=> $stable(ctrl_q)); // R5
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({carkit_en, serial3_en, serial6_en})); // R7
  AST_IND_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_PASS] && !vbus_valid |-> !vbus_ind); // R9
  AST_SUSP_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !suspend_n |-> !clk_powered); // R10
endmodule

bind ulpi_ifc_ctrl ulpi_ifc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q),
  .vbus_valid(vbus_valid), .suspend_n(suspend_n), .carkit_en(carkit_en),
  .serial3_en(serial3_en), .serial6_en(serial6_en),
  .clk_powered(clk_powered), .vbus_ind(vbus_ind)
);

// File: tb/ulpi_ifc_ctrl_test.sv
`timescale 1ns/1ps
module ulpi_ifc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       fault_in = 1'b0, vbus_valid = 1'b0, suspend_n = 1'b1;
  logic       prot_dis, carkit_en, serial3_en, serial6_en;
  logic       mode_conflict, clk_powered, vbus_ind;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ulpi_ifc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .fault_in(fault_in),
    .vbus_valid(vbus_valid), .suspend_n(suspend_n), .prot_dis(prot_dis),
    .carkit_en(carkit_en), .serial3_en(serial3_en), .serial6_en(serial6_en),
    .mode_conflict(mode_conflict), .clk_powered(clk_powered), .vbus_ind(vbus_ind)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(6'h07, v);
    check("R1 readback", v, 8'h00);
    check("R1 outputs", {prot_dis, carkit_en, serial3_en, serial6_en, mode_conflict}, 0);
  endtask

  task automatic t_load();
    logic [7:0] v;
    wr(6'h07, 8'hFF); rd(6'h07, v);
    check("R2 load with reserved bit", v, 8'hEF);
    wr(6'h07, 8'h81); rd(6'h07, v);
    check("R2 load replaces", v, 8'h81);
    check("R6 prot_dis/serial6", {prot_dis, serial6_en}, 2'b11);
  endtask

  task automatic t_set();
    logic [7:0] v;
    wr(6'h08, 8'h40); rd(6'h07, v);
    check("R3 set ORs", v, 8'hC1);
    wr(6'h08, 8'h10); rd(6'h07, v);
    check("R3 reserved not set", v, 8'hC1);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(6'h09, 8'h80); rd(6'h07, v);
    check("R4 clear masks", v, 8'h41);
    wr(6'h09, 8'h00); rd(6'h07, v);
    check("R4 zero mask keeps", v, 8'h41);
  endtask

  task automatic t_window();
    logic [7:0] v;
    rd(6'h08, v); check("R5 read set alias", v, 8'h41);
    rd(6'h09, v); check("R5 read clear alias", v, 8'h41);
    rd(6'h06, v); check("R5 read below window", v, 8'h00);
    rd(6'h0A, v); check("R5 read above window", v, 8'h00);
    wr(6'h0A, 8'hFF); wr(6'h06, 8'h00); rd(6'h07, v);
    check("R5 outside writes ignored", v, 8'h41);
  endtask

  task automatic t_modes();
    wr(6'h07, 8'h04);
    check("R6 carkit", {carkit_en, serial3_en, serial6_en, mode_conflict}, 4'b1000);
    wr(6'h07, 8'h02);
    check("R6 serial3", {carkit_en, serial3_en, serial6_en, mode_conflict}, 4'b0100);
    wr(6'h07, 8'h06);
    check("R7 two modes", {carkit_en, serial3_en, serial6_en, mode_conflict}, 4'b0001);
    wr(6'h07, 8'h07);
    check("R7 three modes", {carkit_en, serial3_en, serial6_en, mode_conflict}, 4'b0001);
  endtask

  task automatic t_indicator();
    for (int cfg = 0; cfg < 4; cfg++) begin
      wr(6'h07, 8'(cfg << 5));
      for (int s = 0; s < 4; s++) begin
        logic c, e;
        @(negedge clk);
        fault_in = s[0]; vbus_valid = s[1];
        #1;
        c = s[0] ^ cfg[0];
        e = cfg[1] ? c : (c & s[1]);
        check(cfg[1] ? "R8 invert, unqualified" : "R9 qualified by vbus", vbus_ind, e);
      end
    end
  endtask

  task automatic t_clock();
    suspend_n = 1'b1;
    wr(6'h07, 8'h01); #1 check("R10 serial, bit3=0", clk_powered, 0);
    wr(6'h07, 8'h09); #1 check("R10 serial, bit3=1", clk_powered, 1);
    @(negedge clk); suspend_n = 1'b0; #1 check("R10 suspended", clk_powered, 0);
    @(negedge clk); suspend_n = 1'b1;
    wr(6'h07, 8'h04); #1 check("R10 no serial, bit3=0", clk_powered, 1);
    wr(6'h07, 8'h03); #1 check("R10 conflict, bit3=0", clk_powered, 1);
    wr(6'h07, 8'h02); #1 check("R10 serial3, bit3=0", clk_powered, 0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_set();
    t_clear();
    t_window();
    t_modes();
    t_indicator();
    t_clock();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule